// File: doc/BRIEF.md
# Exception Control Register Unit

This block holds the privileged state a small 32-bit RISC core needs to enter and leave exception handlers. It keeps three registers: a processor status word (interrupt mask, user-mode bit, two exception-level bits and a global interrupt enable), a cause word (branch-delay flag, pending-interrupt bits and the exception code), and the saved exception return address. Software reads and writes them through a move-to / move-from port addressed by a 5-bit register number.

The pipeline raises a one-cycle exception-entry pulse with the cause code, the faulting instruction address and a delay-slot flag. The unit then asks for a fetch redirect to the fixed handler address, records the cause and the return address, and sets the exception-level bit. A one-cycle return pulse asks for a redirect to the saved address and clears the exception-level bit. A kernel-mode flag and the sampled interrupt request lines are driven as plain outputs. The redirect request and the register port are plain control pins: the receiver cannot stall them, so there is no back-pressure. A pulse is acted on in the cycle it is seen.

Top module: `exc_ctrl_regs`

## Requirements
- R1: After reset, status (register 12) reads 0x0000_0004 (only ERL, bit 2, set), cause (register 13) reads 0 while the request lines are low, the saved address (register 14) reads 0, kernel_mode is 1 and redirect_valid is 0.
- R2: A move-to register 12 stores IM from bits 15:8, UM from bit 4, ERL from bit 2, EXL from bit 1 and IE from bit 0. A read returns the written value ANDed with 0x0000_FF17.
- R3: Register numbers other than 12, 13 and 14 read as zero. Writes to them change no register.
- R4: kernel_mode is 1 when UM is 0, or when EXL or ERL is 1. Otherwise it is 0.
- R5: In an exc_take cycle, redirect_valid is 1 and redirect_pc is 0x8000_0180 in that same cycle. From the next cycle on, EXL is 1, cause bits 6:2 hold exc_code, cause bit 31 (BD) is 0 and register 14 holds exc_pc.
- R6: When exc_in_delay is 1 at entry, BD (cause bit 31) becomes 1 and register 14 holds exc_pc minus 4.
- R7: In an exc_return cycle without exc_take, redirect_valid is 1 and redirect_pc equals the saved address. From the next cycle on, EXL is 0.
- R8: Cause bits 15:8 and irq_pending equal irq_lines as sampled at the previous rising edge. A move-to register 13 changes no cause bit.
- R9: When exc_take is high, exc_return and any move-to in the same cycle have no effect, and redirect_pc is the handler address.
- R10: A move-to register 14 stores all 32 bits, and reads return them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_wr_en | input | 1 | Move-to strobe |
| csr_addr | input | 5 | Register number for read and write |
| csr_wdata | input | 32 | Move-to data |
| csr_rdata | output | 32 | Move-from data, combinational from csr_addr |
| exc_take | input | 1 | Exception-entry pulse |
| exc_code | input | 5 | Exception code recorded at entry |
| exc_pc | input | 32 | Address of the faulting instruction |
| exc_in_delay | input | 1 | Faulting instruction sat in a branch delay slot |
| exc_return | input | 1 | Return-from-exception pulse |
| irq_lines | input | 8 | External interrupt request lines |
| redirect_valid | output | 1 | Fetch redirect request this cycle |
| redirect_pc | output | 32 | Redirect target |
| kernel_mode | output | 1 | Processor runs with kernel privilege |
| irq_pending | output | 8 | Sampled interrupt requests |

## Verification
The assertions assume that every input is a known value once reset is released and that it changes only between rising edges. They make no assumption about pulse spacing, so entry and return may arrive back to back or together. The bench changes every input on the falling clock edge and holds each strobe for exactly one cycle. The entry, return and move-to collision is driven on purpose to exercise the priority rule. Fault addresses are word-aligned and at least 4, so the delay-slot adjustment never wraps.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int XLEN       = 32;
  localparam int RNUM_W     = 5;
  localparam int IRQ_N      = 8;
  localparam int CODE_W     = 5;
  localparam int INSN_BYTES = 4;

  localparam logic [RNUM_W-1:0] RNUM_STATUS = 5'd12;
  localparam logic [RNUM_W-1:0] RNUM_CAUSE  = 5'd13;
  localparam logic [RNUM_W-1:0] RNUM_EPC    = 5'd14;

  localparam logic [XLEN-1:0] HANDLER_ADDR = 32'h8000_0180;

  // status field positions
  localparam int ST_IM_LSB = 8;
  localparam int ST_UM     = 4;
  localparam int ST_ERL    = 2;
  localparam int ST_EXL    = 1;
  localparam int ST_IE     = 0;

  // cause field positions
  localparam int CA_BD     = 31;
  localparam int CA_PI_LSB = 8;
  localparam int CA_CODE_LSB = 2;

  typedef enum logic [CODE_W-1:0] {
    EXC_INT     = 5'd0,
    EXC_ADEL    = 5'd4,
    EXC_ADES    = 5'd5,
    EXC_IBUS    = 5'd6,
    EXC_DBUS    = 5'd7,
    EXC_SYSCALL = 5'd8,
    EXC_BREAK   = 5'd9,
    EXC_RSVD    = 5'd10,
    EXC_CPU     = 5'd11,
    EXC_OVF     = 5'd12,
    EXC_TRAP    = 5'd13,
    EXC_FPE     = 5'd15
  } exc_code_e;

  typedef struct packed {
    logic [IRQ_N-1:0] im;
    logic             um;
    logic             erl;
    logic             exl;
    logic             ie;
  } status_t;
endpackage

// File: rtl/exc_status_reg.sv
module exc_status_reg
  import exc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  status_t         wfield,
  input  logic            set_exl,
  input  logic            clr_exl,
  output status_t         st,
  output logic [XLEN-1:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st.im  <= '0;
      st.um  <= 1'b0;
      st.erl <= 1'b1;
      st.exl <= 1'b0;
      st.ie  <= 1'b0;
    end else begin
      if (wr_en) st <= wfield;
      if (set_exl)      st.exl <= 1'b1;
      else if (clr_exl) st.exl <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    rdata[ST_IM_LSB +: IRQ_N] = st.im;
    rdata[ST_UM]  = st.um;
    rdata[ST_ERL] = st.erl;
    rdata[ST_EXL] = st.exl;
    rdata[ST_IE]  = st.ie;
  end
endmodule

// File: rtl/exc_cause_reg.sv
module exc_cause_reg
  import exc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IRQ_N-1:0]  irq_lines,
  input  logic              capture,
  input  logic [CODE_W-1:0] code_in,
  input  logic              bd_in,
  output logic [IRQ_N-1:0]  pi,
  output logic [XLEN-1:0]   rdata
);
  logic [CODE_W-1:0] code_q;
  logic              bd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      bd_q   <= 1'b0;
    end else if (capture) begin
      code_q <= code_in;
      bd_q   <= bd_in;
    end
  end

  // one sampling flop per request line
  for (genvar g = 0; g < IRQ_N; g++) begin : g_pi
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pi[g] <= 1'b0;
      else        pi[g] <= irq_lines[g];
    end
  end

  always_comb begin
    rdata = '0;
    rdata[CA_BD] = bd_q;
    rdata[CA_PI_LSB +: IRQ_N] = pi;
    rdata[CA_CODE_LSB +: CODE_W] = code_q;
  end
endmodule

// File: rtl/exc_epc_reg.sv
module exc_epc_reg
  import exc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [XLEN-1:0] wdata,
  input  logic            capture,
  input  logic [XLEN-1:0] fault_pc,
  input  logic            in_delay,
  output logic [XLEN-1:0] epc
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  logic [XLEN-1:0] ret_addr;
  assign ret_addr = in_delay ? (fault_pc - STEP) : fault_pc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       epc <= '0;
    else if (capture) epc <= ret_addr;
    else if (wr_en)   epc <= wdata;
  end
endmodule

// File: rtl/exc_ctrl_regs.sv
module exc_ctrl_regs
  import exc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_wr_en,
  input  logic [RNUM_W-1:0] csr_addr,
  input  logic [XLEN-1:0]   csr_wdata,
  output logic [XLEN-1:0]   csr_rdata,
  input  logic              exc_take,
  input  logic [CODE_W-1:0] exc_code,
  input  logic [XLEN-1:0]   exc_pc,
  input  logic              exc_in_delay,
  input  logic              exc_return,
  input  logic [IRQ_N-1:0]  irq_lines,
  output logic              redirect_valid,
  output logic [XLEN-1:0]   redirect_pc,
  output logic              kernel_mode,
  output logic [IRQ_N-1:0]  irq_pending
);
  status_t         st;
  status_t         st_wfield;
  logic [XLEN-1:0] st_rdata, ca_rdata, epc_q;
  logic            sw_wr, wr_status, wr_epc, do_return;

  // entry wins over software writes and over return
  assign sw_wr     = csr_wr_en && !exc_take;
  assign wr_status = sw_wr && (csr_addr == RNUM_STATUS);
  assign wr_epc    = sw_wr && (csr_addr == RNUM_EPC);
  assign do_return = exc_return && !exc_take;

  assign st_wfield.im  = csr_wdata[ST_IM_LSB +: IRQ_N];
  assign st_wfield.um  = csr_wdata[ST_UM];
  assign st_wfield.erl = csr_wdata[ST_ERL];
  assign st_wfield.exl = csr_wdata[ST_EXL];
  assign st_wfield.ie  = csr_wdata[ST_IE];

  exc_status_reg u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_status),
    .wfield  (st_wfield),
    .set_exl (exc_take),
    .clr_exl (do_return),
    .st      (st),
    .rdata   (st_rdata)
  );

  exc_cause_reg u_cause (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_lines (irq_lines),
    .capture   (exc_take),
    .code_in   (exc_code),
    .bd_in     (exc_in_delay),
    .pi        (irq_pending),
    .rdata     (ca_rdata)
  );

  exc_epc_reg u_epc (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_epc),
    .wdata    (csr_wdata),
    .capture  (exc_take),
    .fault_pc (exc_pc),
    .in_delay (exc_in_delay),
    .epc      (epc_q)
  );

  always_comb begin
    unique case (csr_addr)
      RNUM_STATUS: csr_rdata = st_rdata;
      RNUM_CAUSE:  csr_rdata = ca_rdata;
      RNUM_EPC:    csr_rdata = epc_q;
      default:     csr_rdata = '0;
    endcase
  end

  assign redirect_valid = exc_take || exc_return;
  assign redirect_pc    = exc_take ? HANDLER_ADDR : epc_q;
  assign kernel_mode    = !st.um || st.exl || st.erl;
endmodule

// File: rtl/exc_ctrl_checker.sv
module exc_ctrl_checker
  import exc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              csr_wr_en,
  input logic [RNUM_W-1:0] csr_addr,
  input logic [XLEN-1:0]   csr_wdata,
  input logic              exc_take,
  input logic [XLEN-1:0]   exc_pc,
  input logic              exc_in_delay,
  input logic              exc_return,
  input logic [IRQ_N-1:0]  irq_lines,
  input logic              redirect_valid,
  input logic [XLEN-1:0]   redirect_pc,
  input logic              kernel_mode,
  input logic [IRQ_N-1:0]  irq_pending,
  input logic              exl_q,
  input logic [XLEN-1:0]   epc_q
);
  a_r5_entry_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |-> (redirect_valid && redirect_pc == HANDLER_ADDR));

  a_r5_exl_set: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> exl_q);

  a_r6_delay_epc: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && exc_in_delay) |=> (epc_q == $past(exc_pc) - 32'd4));

  a_r5_plain_epc: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && !exc_in_delay) |=> (epc_q == $past(exc_pc)));

  a_r7_return_target: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_return && !exc_take) |-> (redirect_valid && redirect_pc == epc_q));

  a_r7_exl_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_return && !exc_take) |=> !exl_q);

  a_r4_exl_kernel: assert property (@(posedge clk) disable iff (!rst_n)
    exl_q |-> kernel_mode);

  a_r8_pi_follow: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (irq_pending == $past(irq_lines)));

  a_r10_epc_write: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr_en && csr_addr == RNUM_EPC && !exc_take) |=> (epc_q == $past(csr_wdata)));

  a_r9_no_idle_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_take && !exc_return) |-> !redirect_valid);
endmodule

bind exc_ctrl_regs exc_ctrl_checker u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .csr_wr_en      (csr_wr_en),
  .csr_addr       (csr_addr),
  .csr_wdata      (csr_wdata),
  .exc_take       (exc_take),
  .exc_pc         (exc_pc),
  .exc_in_delay   (exc_in_delay),
  .exc_return     (exc_return),
  .irq_lines      (irq_lines),
  .redirect_valid (redirect_valid),
  .redirect_pc    (redirect_pc),
  .kernel_mode    (kernel_mode),
  .irq_pending    (irq_pending),
  .exl_q          (st.exl),
  .epc_q          (epc_q)
);

// File: tb/test_exc_ctrl_regs.sv
module test_exc_ctrl_regs;
  import exc_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_wr_en = 1'b0;
  logic [4:0]  csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        exc_take = 1'b0;
  logic [4:0]  exc_code = '0;
  logic [31:0] exc_pc = '0;
  logic        exc_in_delay = 1'b0;
  logic        exc_return = 1'b0;
  logic [7:0]  irq_lines = '0;
  logic        redirect_valid;
  logic [31:0] redirect_pc;
  logic        kernel_mode;
  logic [7:0]  irq_pending;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  exc_ctrl_regs i_exc_ctrl_regs (.*);

  typedef struct packed {
    logic [3:0]  req;
    logic [4:0]  addr;
    logic [31:0] wdata;
    logic [31:0] exp_v;
  } vec_t;

  // write then read back; run straight after reset with request lines low
  localparam vec_t VECS [0:8] = '{
    '{4'd2,  5'd12, 32'hFFFF_FFFF, 32'h0000_FF17},  // R2
    '{4'd2,  5'd12, 32'hA5A5_5A5A, 32'h0000_5A12},  // R2
    '{4'd10, 5'd14, 32'hDEAD_BEEF, 32'hDEAD_BEEF},  // R10
    '{4'd10, 5'd14, 32'h0000_0000, 32'h0000_0000},  // R10
    '{4'd3,  5'd7,  32'h1234_5678, 32'h0000_0000},  // R3
    '{4'd3,  5'd31, 32'hFFFF_FFFF, 32'h0000_0000},  // R3
    '{4'd8,  5'd13, 32'hFFFF_FFFF, 32'h0000_0000},  // R8
    '{4'd2,  5'd12, 32'h0000_0010, 32'h0000_0010},  // R2
    '{4'd10, 5'd14, 32'h0040_0100, 32'h0040_0100}   // R10
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic csr_write(input logic [4:0] a, input logic [31:0] d);
    csr_wr_en = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_wr_en = 1'b0;
  endtask

  task automatic csr_read(input logic [4:0] a, output logic [31:0] d);
    csr_addr = a;
    #1 d = csr_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    // R1 reset state, sampled while reset held then just after release
    csr_read(5'd12, rd); check("R1 status", rd, 32'h0000_0004);
    rst_n = 1'b1;
    @(negedge clk);
    csr_read(5'd12, rd); check("R1 status", rd, 32'h0000_0004);
    csr_read(5'd13, rd); check("R1 cause", rd, 32'h0);
    csr_read(5'd14, rd); check("R1 epc", rd, 32'h0);
    check("R1 kernel", {31'b0, kernel_mode}, 32'd1);
    check("R1 redirect", {31'b0, redirect_valid}, 32'd0);

    foreach (VECS[i]) begin
      csr_write(VECS[i].addr, VECS[i].wdata);
      csr_read(VECS[i].addr, rd);
      check($sformatf("R%0d vec%0d", VECS[i].req, i), rd, VECS[i].exp_v);
    end
    // R3 writes to unused numbers left status untouched
    csr_read(5'd12, rd); check("R3 status intact", rd, 32'h0000_0010);

    // R4 kernel derivation; status now UM=1 only
    check("R4 user", {31'b0, kernel_mode}, 32'd0);
    csr_write(5'd12, 32'h0000_0012);
    check("R4 exl", {31'b0, kernel_mode}, 32'd1);
    csr_write(5'd12, 32'h0000_0014);
    check("R4 erl", {31'b0, kernel_mode}, 32'd1);
    csr_write(5'd12, 32'h0000_0000);
    check("R4 um0", {31'b0, kernel_mode}, 32'd1);
    csr_write(5'd12, 32'h0000_0010);

    // R5 plain entry
    exc_take = 1'b1; exc_code = EXC_OVF; exc_pc = 32'h0040_1000; exc_in_delay = 1'b0;
    #1;
    check("R5 redirect_valid", {31'b0, redirect_valid}, 32'd1);
    check("R5 redirect_pc", redirect_pc, 32'h8000_0180);
    @(negedge clk);
    exc_take = 1'b0;
    csr_read(5'd12, rd); check("R5 exl", rd, 32'h0000_0012);
    csr_read(5'd13, rd); check("R5 cause", rd, 32'h0000_0030);
    csr_read(5'd14, rd); check("R5 epc", rd, 32'h0040_1000);
    check("R5 kernel", {31'b0, kernel_mode}, 32'd1);

    // R7 return
    exc_return = 1'b1;
    #1;
    check("R7 redirect_valid", {31'b0, redirect_valid}, 32'd1);
    check("R7 redirect_pc", redirect_pc, 32'h0040_1000);
    @(negedge clk);
    exc_return = 1'b0;
    csr_read(5'd12, rd); check("R7 exl clear", rd, 32'h0000_0010);
    check("R7 kernel", {31'b0, kernel_mode}, 32'd0);
    check("R7 idle redirect", {31'b0, redirect_valid}, 32'd0);

    // R6 delay-slot entry
    exc_take = 1'b1; exc_code = EXC_SYSCALL; exc_pc = 32'h0040_2004; exc_in_delay = 1'b1;
    @(negedge clk);
    exc_take = 1'b0; exc_in_delay = 1'b0;
    csr_read(5'd13, rd); check("R6 cause", rd, 32'h8000_0020);
    csr_read(5'd14, rd); check("R6 epc", rd, 32'h0040_2000);

    // R8 pending lines and ignored writes
    irq_lines = 8'hA5;
    #1;
    check("R8 before edge", {24'b0, irq_pending}, 32'h0);
    @(negedge clk);
    csr_read(5'd13, rd); check("R8 cause pi", rd, 32'h8000_A520);
    check("R8 irq_pending", {24'b0, irq_pending}, 32'h0000_00A5);
    csr_write(5'd13, 32'h0000_0000);
    csr_read(5'd13, rd); check("R8 write ignored", rd, 32'h8000_A520);
    irq_lines = 8'h00;
    @(negedge clk);
    check("R8 lines drop", {24'b0, irq_pending}, 32'h0);

    // R9 entry, return and move-to collide
    exc_take = 1'b1; exc_return = 1'b1; exc_code = EXC_TRAP; exc_pc = 32'h0040_3000;
    csr_wr_en = 1'b1; csr_addr = 5'd14; csr_wdata = 32'h1111_2222;
    #1;
    check("R9 redirect_pc", redirect_pc, 32'h8000_0180);
    @(negedge clk);
    exc_take = 1'b0; exc_return = 1'b0; csr_wr_en = 1'b0;
    csr_read(5'd14, rd); check("R9 epc", rd, 32'h0040_3000);
    csr_read(5'd12, rd); check("R9 exl", rd, 32'h0000_0012);
    csr_read(5'd13, rd); check("R9 cause", rd, 32'h0000_0034);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule